// File: doc/BRIEF.md
# Phase-Offset PWM Channel on a Shared Up-Counter

This block drives a single PWM output. It does not own a counter. It watches the value of a free-running up-counter that it shares with other channels, together with that counter's period length and a strobe that marks the first tick of each period. The output switches to its active level when the counter reaches a programmable phase offset. It returns to its inactive level when the counter reaches phase plus duty. Both values are counted in ticks of the shared counter. A polarity bit chooses whether the active level is high or low.

Software writes the phase, duty and polarity fields one at a time into a shadow bank. The channel keeps running on its active copy until the shared boundary strobe arrives. On the strobe cycle the whole shadow bank moves into the active copy, so every channel on the same timebase switches at the same period edge. The output is registered and reflects the counter value of the previous cycle.

Top module: `pwm_edge_chan`

## Requirements
- R1: While `rst` is high and in the cycle after it, `pwm_o` is 0. Reset clears shadow and active settings to phase 0, duty 0, polarity active-high (`pol_wdata`=0 means active-high, 1 means active-low).
- R2: If 0 < duty < period, phase < period and phase+duty < period, then `pwm_o` in cycle t+1 is active exactly when phase <= `cnt_i` < phase+duty in cycle t.
- R3: If 0 < duty < period, phase < period and phase+duty >= period, then the active window wraps. The output is active when `cnt_i` >= phase or `cnt_i` < phase+duty-period.
- R4: A duty of 0 keeps the output at its inactive level for the whole period.
- R5: A duty equal to or greater than `period_i` keeps the output at its active level for the whole period.
- R6: A phase equal to or greater than `period_i`, with 0 < duty < period, keeps the output inactive.
- R7: A write made on a cycle where `bnd_i` is low changes only the shadow bank. The output keeps following the old settings until the next strobe.
- R8: On a cycle where `bnd_i` is high, the shadow bank is copied to the active bank. The copied values already decide the output produced for that cycle's counter value.
- R9: A write made on the same cycle as `bnd_i` is not part of that copy. It takes effect at the following strobe.
- R10: Polarity is held in the shadow bank like the other fields. When active-low is in force, every output level is inverted.
- R11: Each field has its own write enable. Writing one field leaves the shadow value of the other fields unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_i | input | CNT_W | Value of the shared up-counter, counting 0 to period-1 |
| period_i | input | CNT_W | Period length of the shared counter in ticks |
| bnd_i | input | 1 | High in the cycle where the shared counter is at 0 |
| phase_we | input | 1 | Write enable for the phase shadow field |
| phase_wdata | input | CNT_W | New phase offset in ticks |
| duty_we | input | 1 | Write enable for the duty shadow field |
| duty_wdata | input | CNT_W | New duty in ticks |
| pol_we | input | 1 | Write enable for the polarity shadow field |
| pol_wdata | input | 1 | 0 = active-high, 1 = active-low |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The bench targets the strobe cycle itself. If a design copied the shadow bank one cycle late, the first tick of each new period would still show the old shape. If a design let a write on the strobe cycle slip into the copy, the new duty would show one period early. Wrapped windows are checked in two period lengths: a design that ignored the wrap would cut off the tail that falls past the counter's restart. Duty values of 0, exactly the period and above the period are run, as well as a phase beyond the period. An off-by-one compare would leave a stray active tick in these cases. A change of polarity alone must wait for the boundary like the other fields.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

    localparam int unsigned CNT_W = 16;
    localparam int unsigned SUM_W = CNT_W + 1;

    typedef logic [CNT_W-1:0] tick_t;

    typedef struct packed {
        tick_t phase;
        tick_t duty;
        logic  act_low;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_FULL  = 2'd1,
        WIN_PLAIN = 2'd2,
        WIN_WRAP  = 2'd3
    } win_kind_e;

    localparam chan_cfg_t CFG_RESET = '{phase: '0, duty: '0, act_low: 1'b0};

    function automatic logic [SUM_W-1:0] widen(input tick_t v);
        return {1'b0, v};
    endfunction

    function automatic win_kind_e classify(input chan_cfg_t c, input tick_t per);
        logic [SUM_W-1:0] s;
        s = widen(c.phase) + widen(c.duty);
        if (c.duty == '0)            return WIN_NONE;
        else if (c.duty >= per)      return WIN_FULL;
        else if (c.phase >= per)     return WIN_NONE;
        else if (s < widen(per))     return WIN_PLAIN;
        else                         return WIN_WRAP;
    endfunction

endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
    import pwm_edge_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bnd_i,
    input  logic      phase_we,
    input  tick_t     phase_wdata,
    input  logic      duty_we,
    input  tick_t     duty_wdata,
    input  logic      pol_we,
    input  logic      pol_wdata,
    output chan_cfg_t eff_cfg_o
);

    chan_cfg_t shadow_q;
    chan_cfg_t active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= CFG_RESET;
        end else begin
            if (phase_we) shadow_q.phase   <= phase_wdata;
            if (duty_we)  shadow_q.duty    <= duty_wdata;
            if (pol_we)   shadow_q.act_low <= pol_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        active_q <= CFG_RESET;
        else if (bnd_i) active_q <= shadow_q;
    end

    // Settings that govern this cycle: a strobe hands over the shadow bank at once.
    always_comb begin
        eff_cfg_o = bnd_i ? shadow_q : active_q;
    end

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bnd_i |=> $stable(active_q));

    // R8
    bnd_copy_chk: assert property (@(posedge clk) disable iff (rst)
        bnd_i |=> (active_q == $past(shadow_q)));

    // R11
    phase_write_chk: assert property (@(posedge clk) disable iff (rst)
        phase_we |=> (shadow_q.phase == $past(phase_wdata)));

    // R11
    duty_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !duty_we |=> (shadow_q.duty == $past(shadow_q.duty)));

endmodule

// File: rtl/pwm_window_cmp.sv
module pwm_window_cmp
    import pwm_edge_pkg::*;
(
    input  tick_t     cnt_i,
    input  tick_t     period_i,
    input  chan_cfg_t cfg_i,
    output logic      level_o
);

    win_kind_e        kind;
    logic [SUM_W-1:0] trail;
    logic [SUM_W-1:0] tail;
    logic             after_lead;

    always_comb begin
        kind       = classify(cfg_i, period_i);
        trail      = widen(cfg_i.phase) + widen(cfg_i.duty);
        tail       = trail - widen(period_i);
        after_lead = (cnt_i >= cfg_i.phase);
        unique case (kind)
            WIN_NONE:  level_o = 1'b0;
            WIN_FULL:  level_o = 1'b1;
            WIN_PLAIN: level_o = after_lead && (widen(cnt_i) < trail);
            WIN_WRAP:  level_o = after_lead || (widen(cnt_i) < tail);
            default:   level_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    input  logic act_low_i,
    output logic pwm_o
);

    logic pwm_q;

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= level_i ^ act_low_i;
    end

    assign pwm_o = pwm_q;

    // R10
    polarity_chk: assert property (@(posedge clk) disable iff (rst)
        (level_i && !act_low_i) |=> pwm_o);

endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan
    import pwm_edge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             bnd_i,
    input  logic             phase_we,
    input  logic [CNT_W-1:0] phase_wdata,
    input  logic             duty_we,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             pol_we,
    input  logic             pol_wdata,
    output logic             pwm_o
);

    chan_cfg_t eff_cfg;
    logic      level;

    pwm_shadow_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .bnd_i       (bnd_i),
        .phase_we    (phase_we),
        .phase_wdata (phase_wdata),
        .duty_we     (duty_we),
        .duty_wdata  (duty_wdata),
        .pol_we      (pol_we),
        .pol_wdata   (pol_wdata),
        .eff_cfg_o   (eff_cfg)
    );

    pwm_window_cmp u_cmp (
        .cnt_i    (cnt_i),
        .period_i (period_i),
        .cfg_i    (eff_cfg),
        .level_o  (level)
    );

    pwm_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .level_i   (level),
        .act_low_i (eff_cfg.act_low),
        .pwm_o     (pwm_o)
    );

    // R4
    duty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (eff_cfg.duty == '0) |=> (pwm_o == $past(eff_cfg.act_low)));

    // R5
    duty_full_chk: assert property (@(posedge clk) disable iff (rst)
        (eff_cfg.duty >= period_i) |=> (pwm_o == !$past(eff_cfg.act_low)));

    // R2
    lead_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (eff_cfg.duty != '0 && eff_cfg.phase < period_i && cnt_i == eff_cfg.phase)
        |=> (pwm_o != $past(eff_cfg.act_low)));

    // R6
    phase_out_chk: assert property (@(posedge clk) disable iff (rst)
        (eff_cfg.duty != '0 && eff_cfg.duty < period_i && eff_cfg.phase >= period_i)
        |=> (pwm_o == $past(eff_cfg.act_low)));

endmodule

// File: tb/pwm_edge_chan_test.sv
module pwm_edge_chan_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cnt = '0;
    logic [W-1:0] period = 16'd10;
    logic         bnd = 1'b0;
    logic         ph_we = 1'b0, du_we = 1'b0, pl_we = 1'b0;
    logic [W-1:0] ph_d = '0, du_d = '0;
    logic         pl_d = 1'b0;
    logic         pwm;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0, m_per = 10;
    int sh_ph = 0, sh_du = 0, sh_pl = 0;
    int ac_ph = 0, ac_du = 0, ac_pl = 0;
    logic exp_q = 1'b0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_edge_chan uut (
        .clk(clk), .rst(rst), .cnt_i(cnt), .period_i(period), .bnd_i(bnd),
        .phase_we(ph_we), .phase_wdata(ph_d), .duty_we(du_we), .duty_wdata(du_d),
        .pol_we(pl_we), .pol_wdata(pl_d), .pwm_o(pwm)
    );

    function automatic logic ref_level(int c, int ph, int du, int per, int pl);
        logic on;
        if (du == 0)                on = 1'b0;
        else if (du >= per)         on = 1'b1;
        else if (ph >= per)         on = 1'b0;
        else if (ph + du < per)     on = (c >= ph) && (c < ph + du);
        else                        on = (c >= ph) || (c < ph + du - per);
        return on ^ (pl != 0);
    endfunction

    // One clock: called at a falling edge with the write inputs already set.
    task automatic step();
        string tag;
        cnt = 16'(m_cnt);
        bnd = (m_cnt == 0);
        if (rst) begin
            exp_q = 1'b0;
            sh_ph = 0; sh_du = 0; sh_pl = 0;
            ac_ph = 0; ac_du = 0; ac_pl = 0;
        end else begin
            if (bnd) begin
                ac_ph = sh_ph; ac_du = sh_du; ac_pl = sh_pl;
            end
            exp_q = ref_level(m_cnt, ac_ph, ac_du, m_per, ac_pl);
            if (ph_we) sh_ph = int'(ph_d);
            if (du_we) sh_du = int'(du_d);
            if (pl_we) sh_pl = int'(pl_d);
        end
        tag = (bnd && !rst) ? "R8" : cur_tag;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (pwm !== exp_q) begin
            errors++;
            $display("FAIL %s: pwm_o=%0b expected %0b (cnt %0d)", tag, pwm, exp_q, m_cnt);
        end
        ph_we = 1'b0; du_we = 1'b0; pl_we = 1'b0;
        m_cnt = (m_cnt + 1) % m_per;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_cnt(int c);
        while (m_cnt != c) step();
    endtask

    task automatic wr(bit pe, int p, bit de, int d, bit le, int l);
        ph_we = pe; ph_d = 16'(p);
        du_we = de; du_d = 16'(d);
        pl_we = le; pl_d = (l != 0);
        step();
    endtask

    initial begin
        @(negedge clk);
        cur_tag = "R1";
        run(3);
        rst = 1'b0;
        run(12);

        // R7: mid-period write must not show until the strobe
        cur_tag = "R7";
        wait_cnt(4);
        wr(1, 2, 1, 3, 0, 0);
        wait_cnt(0);
        // R2: plain window 2..4
        cur_tag = "R2";
        run(20);

        // R9: duty written on the strobe cycle waits one more period
        cur_tag = "R9";
        wait_cnt(0);
        wr(0, 0, 1, 5, 0, 0);
        run(19);

        // R3: wrapped window, phase 7 duty 6 -> 7..9 and 0..2
        cur_tag = "R3";
        wait_cnt(3);
        wr(1, 7, 1, 6, 0, 0);
        run(25);

        // R11: phase alone changes, duty 6 kept -> 1..6
        cur_tag = "R11";
        wait_cnt(2);
        wr(1, 1, 0, 0, 0, 0);
        run(22);

        // R4: duty 0
        cur_tag = "R4";
        wr(0, 0, 1, 0, 0, 0);
        run(22);

        // R5: duty equal to and above the period
        cur_tag = "R5";
        wr(0, 0, 1, 10, 0, 0);
        run(22);
        wr(0, 0, 1, 12, 0, 0);
        run(22);

        // R6: phase beyond the period
        cur_tag = "R6";
        wr(1, 12, 1, 3, 0, 0);
        run(22);

        // R10: polarity inverted, window 2..5
        cur_tag = "R10";
        wait_cnt(5);
        wr(1, 2, 1, 4, 1, 1);
        run(25);

        // Second period length after a fresh reset
        cur_tag = "R1";
        rst = 1'b1;
        m_per = 7; period = 16'd7; m_cnt = 0;
        run(3);
        rst = 1'b0;
        run(8);
        cur_tag = "R3";
        wr(1, 5, 1, 4, 0, 0);
        run(21);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule